// File: doc/BRIEF.md
# Raster-Operation Block Transfer Engine

This block is a 2D transfer engine for 32-bit pixels stored row by row in linear memory. It takes commands as a stream of 32-bit words. A header word selects one of three operations: a solid fill given by width and height, a solid fill given by corner coordinates, or a rectangle copy from a source area. The header is followed by a control word that holds an 8-bit raster operation (ROP) and the destination pitch. The remaining argument words give the rectangle, the addresses, and either a fill colour or the source pitch.

For each pixel the engine can read the source and the destination over a simple memory port, then writes one result word. Each bit of the result is looked up in the ROP truth table, indexed by the matching bits of pattern, source and destination. A fill uses the colour as pattern and zero as source. A copy uses the fetched word as source and zero as pattern. The destination is fetched only when the ROP result depends on it.

The controller is one state machine with these states:
- `S_HDR`: waits for a header.
- `S_ARGS`: collects the argument words.
- `S_CHECK`: loads the pixel walker, or goes straight to `S_DONE` for an empty rectangle.
- `S_RSRC` / `S_LSRC`: issue and latch the source read.
- `S_RDST` / `S_LDST`: issue and latch the destination read.
- `S_WR`: writes a pixel. It loops back to the first access state of the next pixel, or goes to `S_DONE` after the last one.
- `S_DONE`: pulses done and returns to `S_HDR`.
- `S_ERR`: entered from `S_HDR` on a header that is not recognised. The engine stays there until reset.

Top module: `blt_engine`

## Requirements
- R1: A command word is taken when `cmd_valid` and `cmd_ready` are both high. The header has the client field in bits [31:29], which must equal 2, and the opcode in bits [28:22]. Opcode 0x40 (fill) is followed by 4 words and opcodes 0x43 (copy) and 0x50 (XY fill) by 5. The control word has the ROP in bits [23:16] and the destination pitch in bytes in bits [15:0].
- R2: A header with a client other than 2, or with an opcode that is not listed in R1, raises `err` in the next cycle. `err` then stays high until reset, and during that time `cmd_ready`, `mem_rd` and `mem_wr` are held low.
- R3: Fill (0x40) takes these words in order: dimensions (height in lines in [31:16], width in bytes in [15:0]), destination address, colour. It writes every pixel with 0 ≤ x < width/4 and 0 ≤ y < height at destination + y·pitch + 4x.
- R4: XY fill (0x50) takes these words in order: top-left Y1:X1, bottom-right Y2:X2 (Y in the upper 16 bits of each), destination address, colour. It writes the pixels with X1 ≤ x < X2 and Y1 ≤ y < Y2 at destination + y·pitch + 4x.
- R5: Copy (0x43) takes these words in order: dimensions, destination address, source pitch in bits [15:0], source address. For every pixel it reads the source at source + y·srcpitch + 4x before it writes the destination.
- R6: Result bit i equals ROP bit {p[i], s[i], d[i]}, with the pattern bit as the MSB of the index. Pattern is the colour for fills and 0 for copies. Source is 0 for fills.
- R7: The destination is read only when the ROP depends on the destination bit, that is when {rop[7],rop[5],rop[3],rop[1]} differs from {rop[6],rop[4],rop[2],rop[0]}. The source is read only for copies. The number of reads equals the pixel count times the number of operands that are fetched.
- R8: Pixels are written once each in row-major order: x rises first, then y.
- R9: `mem_be` bits [2:0] follow header bit 20 and `mem_be` bit 3 follows header bit 21. Only enabled bytes are changed.
- R10: `done` is high for exactly one cycle, in the cycle after the last write. A rectangle with zero width or height makes no memory access and still pulses `done`.
- R11: Read data is taken from `mem_rdata` in the cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Engine accepts a command word |
| cmd_data | input | 32 | Command word |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Byte enables for writes |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_rd` |
| done | output | 1 | One-cycle pulse at the end of a command |
| err | output | 1 | Sticky flag for an unrecognised header |

## Verification
The cycle cost of a pixel is fixed by its ROP and its command type:
- one write cycle;
- plus two cycles for each operand that is read.

`done` follows the final write by one cycle, and `err` follows the rejected header by one cycle. The bench drives and samples on falling edges. It waits for the `done` pulse before it compares all of memory with its own model, so no check depends on the exact pixel count per cycle. Read and write counts and the write address order are tallied at every rising edge and then checked once per command.

// File: rtl/blt_pkg.sv
package blt_pkg;

    localparam logic [2:0] CLIENT_2D = 3'd2;
    localparam logic [6:0] OP_FILL   = 7'h40;
    localparam logic [6:0] OP_COPY   = 7'h43;
    localparam logic [6:0] OP_XYFILL = 7'h50;

    typedef enum logic [1:0] {K_FILL, K_COPY, K_XYFILL} blt_kind_e;

    // The ROP uses the destination when flipping the d index bit changes the output.
    function automatic logic rop_uses_dst(input logic [7:0] rop);
        return {rop[7], rop[5], rop[3], rop[1]} != {rop[6], rop[4], rop[2], rop[0]};
    endfunction

endpackage

// File: rtl/blt_rop.sv
module blt_rop #(
    parameter int W = 32
) (
    input  logic [7:0]   rop,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    output logic [W-1:0] res
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res[i] = rop[{pat[i], src[i], dst[i]}];
    end
endmodule

// File: rtl/blt_walker.sv
module blt_walker #(
    parameter int CW = 16,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] x0,
    input  logic [CW-1:0] y0,
    input  logic [CW-1:0] x1,
    input  logic [CW-1:0] y1,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] dst_pitch,
    input  logic [AW-1:0] src_base,
    input  logic [CW-1:0] src_pitch,
    output logic [AW-1:0] dst_addr,
    output logic [AW-1:0] src_addr,
    output logic          last
);
    logic [CW-1:0] x, y;
    logic [CW:0]   xn, yn;
    logic          row_end;

    assign xn      = {1'b0, x} + 1'b1;
    assign yn      = {1'b0, y} + 1'b1;
    assign row_end = (xn == {1'b0, x1});
    assign last    = row_end && (yn == {1'b0, y1});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (load) begin
            x <= x0;
            y <= y0;
        end else if (step) begin
            if (row_end) begin
                x <= x0;
                y <= yn[CW-1:0];
            end else begin
                x <= xn[CW-1:0];
            end
        end
    end

    logic [CW-1:0] xr, yr;
    assign xr = x - x0;
    assign yr = y - y0;

    assign dst_addr = dst_base + AW'(y) * AW'(dst_pitch) + (AW'(x) << 2);
    assign src_addr = src_base + AW'(yr) * AW'(src_pitch) + (AW'(xr) << 2);
endmodule

// File: rtl/blt_engine.sv
module blt_engine
    import blt_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int NARG = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [31:0]     cmd_data,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be,
    input  logic [DW-1:0]   mem_rdata,
    output logic            done,
    output logic            err
);
    localparam int IW = $clog2(NARG + 1);

    typedef enum logic [3:0] {
        S_HDR, S_ARGS, S_CHECK, S_RSRC, S_LSRC,
        S_RDST, S_LDST, S_WR, S_DONE, S_ERR
    } st_e;

    st_e           st, st_n;
    logic [31:0]   args [NARG];
    logic [IW-1:0] aidx, alast;
    blt_kind_e     kind;
    logic [1:0]    wmask;
    logic [DW-1:0] src_q, dst_q;
    logic          acc;

    assign acc = cmd_valid && cmd_ready;

    // header decode
    logic          hdr_ok;
    blt_kind_e     hdr_kind;
    logic [IW-1:0] hdr_last;
    always_comb begin
        hdr_ok   = cmd_data[31:29] == CLIENT_2D;
        hdr_kind = K_FILL;
        hdr_last = IW'(3);
        unique case (cmd_data[28:22])
            OP_FILL:   begin hdr_kind = K_FILL;   hdr_last = IW'(3); end
            OP_COPY:   begin hdr_kind = K_COPY;   hdr_last = IW'(4); end
            OP_XYFILL: begin hdr_kind = K_XYFILL; hdr_last = IW'(4); end
            default:   hdr_ok = 1'b0;
        endcase
    end

    // argument field decode
    logic [7:0]    rop;
    logic [CW-1:0] pitch, spitch, x0, y0, x1, y1;
    logic [AW-1:0] dbase, sbase;
    logic [DW-1:0] colour;
    always_comb begin
        rop    = args[0][23:16];
        pitch  = args[0][CW-1:0];
        x0     = '0;
        y0     = '0;
        x1     = args[1][CW-1:0] >> 2;
        y1     = args[1][31:16];
        dbase  = AW'(args[2]);
        colour = DW'(args[3]);
        spitch = '0;
        sbase  = '0;
        unique case (kind)
            K_FILL: ;
            K_COPY: begin
                colour = '0;
                spitch = args[3][CW-1:0];
                sbase  = AW'(args[4]);
            end
            K_XYFILL: begin
                x0     = args[1][CW-1:0];
                y0     = args[1][31:16];
                x1     = args[2][CW-1:0];
                y1     = args[2][31:16];
                dbase  = AW'(args[3]);
                colour = DW'(args[4]);
            end
            default: ;
        endcase
    end

    logic need_dst, is_copy, empty, last;
    st_e  first_op;
    assign need_dst = rop_uses_dst(rop);
    assign is_copy  = (kind == K_COPY);
    assign empty    = (x1 <= x0) || (y1 <= y0);
    assign first_op = is_copy ? S_RSRC : (need_dst ? S_RDST : S_WR);

    logic [AW-1:0] dst_addr, src_addr;
    blt_walker #(.CW(CW), .AW(AW)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .load(st == S_CHECK), .step(st == S_WR),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .dst_base(dbase), .dst_pitch(pitch),
        .src_base(sbase), .src_pitch(spitch),
        .dst_addr(dst_addr), .src_addr(src_addr), .last(last)
    );

    logic [DW-1:0] rop_res;
    blt_rop #(.W(DW)) u_rop (
        .rop(rop), .pat(colour),
        .src(is_copy ? src_q : '0),
        .dst(need_dst ? dst_q : '0),
        .res(rop_res)
    );

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            S_HDR:   if (acc) st_n = hdr_ok ? S_ARGS : S_ERR;
            S_ARGS:  if (acc && aidx == alast) st_n = S_CHECK;
            S_CHECK: st_n = empty ? S_DONE : first_op;
            S_RSRC:  st_n = S_LSRC;
            S_LSRC:  st_n = need_dst ? S_RDST : S_WR;
            S_RDST:  st_n = S_LDST;
            S_LDST:  st_n = S_WR;
            S_WR:    st_n = last ? S_DONE : first_op;
            S_DONE:  st_n = S_HDR;
            S_ERR:   st_n = S_ERR;
            default: st_n = S_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_HDR;
        else        st <= st_n;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NARG; i++) args[i] <= '0;
            aidx  <= '0;
            alast <= '0;
            kind  <= K_FILL;
            wmask <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            if (st == S_HDR && acc) begin
                kind  <= hdr_kind;
                alast <= hdr_last;
                wmask <= cmd_data[21:20];
                aidx  <= '0;
            end
            if (st == S_ARGS && acc) begin
                args[aidx] <= cmd_data;
                aidx       <= aidx + 1'b1;
            end
            if (st == S_LSRC) src_q <= mem_rdata;
            if (st == S_LDST) dst_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (st == S_HDR) || (st == S_ARGS);
        mem_rd    = (st == S_RSRC) || (st == S_RDST);
        mem_wr    = (st == S_WR);
        mem_addr  = (st == S_RSRC) ? src_addr : dst_addr;
        mem_wdata = rop_res;
        mem_be    = {wmask[1], {(DW/8-1){wmask[0]}}};
        done      = (st == S_DONE);
        err       = (st == S_ERR);
    end

    a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!cmd_ready && !mem_rd && !mem_wr));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_wr) || $past(st) == S_CHECK));
endmodule

// File: tb/tb_blt_engine.sv
module tb_blt_engine;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [31:0] cmd_data = 0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        done, err;

    always #4 clk = ~clk;

    blt_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .done(done), .err(err)
    );

    int checks = 0, errors = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] sh  [0:1023];

    int nrd, nwr, order_bad;
    int ex, ey, ex0, ex1, ebase, epitch;

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[11:2]];
            nrd = nrd + 1;
        end
        if (mem_wr) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            nwr = nwr + 1;
            if (mem_addr != 32'(ebase + ey * epitch + 4 * ex)) order_bad = order_bad + 1;
            if (ex + 1 == ex1) begin ex = ex0; ey = ey + 1; end
            else ex = ex + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ropf(input logic [7:0] r, input logic [31:0] p,
                                         input logic [31:0] s, input logic [31:0] d);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) o[i] = r[{p[i], s[i], d[i]}];
        return o;
    endfunction

    function automatic logic dep_d(input logic [7:0] r);
        return {r[7], r[5], r[3], r[1]} != {r[6], r[4], r[2], r[0]};
    endfunction

    task automatic send(input logic [31:0] w);
        cmd_data  = w;
        cmd_valid = 1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    localparam int DP = 64, SP = 128, SB = 32'h800;

    // kind: 0 fill, 1 copy, 2 xy fill
    task automatic run_cmd(input int kind, input logic [7:0] r, input logic [1:0] wm,
                           input int x0, input int y0, input int x1, input int y1,
                           input int db, input logic [31:0] col, input string req);
        logic [6:0]  op;
        logic [31:0] hdr, d, s, p, v, mask;
        int npix, nops, waitc;
        op   = (kind == 0) ? 7'h40 : (kind == 1) ? 7'h43 : 7'h50;
        hdr  = {3'd2, op, wm, 16'h0, (kind == 0) ? 4'd3 : 4'd4};
        mask = {{8{wm[1]}}, {24{wm[0]}}};
        npix = (x1 > x0 && y1 > y0) ? (x1 - x0) * (y1 - y0) : 0;
        nops = (kind == 1 ? 1 : 0) + (dep_d(r) ? 1 : 0);
        for (int y = y0; y < y1; y++)
            for (int x = x0; x < x1; x++) begin
                d = sh[(db + y * DP + 4 * x) >> 2];
                s = (kind == 1) ? sh[(SB + (y - y0) * SP + 4 * (x - x0)) >> 2] : 32'h0;
                p = (kind == 1) ? 32'h0 : col;
                v = ropf(r, p, s, d);
                sh[(db + y * DP + 4 * x) >> 2] = (v & mask) | (d & ~mask);
            end
        nrd = 0; nwr = 0; order_bad = 0;
        ex = x0; ey = y0; ex0 = x0; ex1 = x1; ebase = db; epitch = DP;
        send(hdr);
        send({8'h03, r, 16'(DP)});
        if (kind == 2) begin
            send({16'(y0), 16'(x0)});
            send({16'(y1), 16'(x1)});
        end else send({16'(y1), 16'(x1 * 4)});
        send(32'(db));
        if (kind == 1) begin
            send(32'(SP));
            send(SB);
        end else send(col);
        waitc = 0;
        while (!done && waitc < 3000) begin @(negedge clk); waitc++; end
        chk(done, {"R10 done pulse ", req}, done, 1);
        @(negedge clk);
        chk(!done, {"R10 done single cycle ", req}, done, 0);
        begin
            int bad = 0, first = -1;
            for (int i = 0; i < 1024; i++)
                if (mem[i] !== sh[i]) begin bad++; if (first < 0) first = i; end
            chk(bad == 0, {req, " memory contents"}, (first < 0) ? 0 : mem[first],
                (first < 0) ? 0 : sh[first]);
        end
        chk(nwr == npix, {"R8 write count ", req}, nwr, npix);
        chk(order_bad == 0, {"R8 row-major order ", req}, order_bad, 0);
        chk(nrd == npix * nops, {"R7 read count ", req}, nrd, npix * nops);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = $urandom;
            sh[i]  = mem[i];
        end
        do_reset();
        chk(cmd_ready == 1, "R1 reset ready", cmd_ready, 1);
        chk(!done && !err, "R2 reset flags", {done, err}, 0);
        chk(!mem_rd && !mem_wr, "R11 reset idle port", {mem_rd, mem_wr}, 0);

        run_cmd(0, 8'hF0, 2'b11, 0, 0, 4, 3, 32'h040, 32'h00330066, "R3 fill pattern");
        run_cmd(1, 8'hCC, 2'b11, 0, 0, 3, 4, 32'h100, 0, "R5 copy source");
        run_cmd(0, 8'hAA, 2'b11, 0, 0, 2, 2, 32'h200, 32'hDEADBEEF, "R6 keep dest");
        run_cmd(0, 8'h55, 2'b11, 0, 0, 5, 2, 32'h300, 0, "R6 invert dest");
        run_cmd(2, 8'hF0, 2'b11, 2, 1, 6, 4, 32'h400, 32'h12345678, "R4 xy fill");
        run_cmd(2, 8'hF0, 2'b11, 3, 2, 3, 5, 32'h400, 32'hFFFFFFFF, "R10 empty xy");
        run_cmd(0, 8'hF0, 2'b11, 0, 0, 0, 3, 32'h400, 32'hFFFFFFFF, "R10 empty fill");
        run_cmd(0, 8'hF0, 2'b01, 0, 0, 3, 2, 32'h500, 32'hA5A5A5A5, "R9 rgb only");
        run_cmd(0, 8'hF0, 2'b10, 0, 0, 3, 2, 32'h580, 32'h5A5A5A5A, "R9 alpha only");
        run_cmd(1, 8'h66, 2'b11, 0, 0, 2, 3, 32'h600, 0, "R6 copy xor dest");

        for (int n = 0; n < 20; n++) begin
            int k, xa, ya, w, h;
            k  = $urandom_range(0, 2);
            xa = (k == 2) ? $urandom_range(0, 6) : 0;
            ya = (k == 2) ? $urandom_range(0, 6) : 0;
            w  = $urandom_range(0, 6);
            h  = $urandom_range(0, 5);
            run_cmd(k, 8'($urandom), 2'($urandom_range(1, 3)), xa, ya, xa + w, ya + h,
                    32'h40 * $urandom_range(0, 16), $urandom, "R6 random");
        end

        // R2: unknown opcode
        nrd = 0; nwr = 0;
        send({3'd2, 7'h41, 2'b11, 20'h3});
        chk(err == 1, "R2 err after bad opcode", err, 1);
        chk(cmd_ready == 0, "R2 ready low in error", cmd_ready, 0);
        cmd_valid = 1; cmd_data = {3'd2, 7'h40, 2'b11, 20'h3};
        repeat (5) @(negedge clk);
        cmd_valid = 0;
        chk(err == 1, "R2 err sticky", err, 1);
        chk(nrd == 0 && nwr == 0, "R2 no memory access", nrd + nwr, 0);

        do_reset();
        chk(err == 0 && cmd_ready == 1, "R2 reset clears err", err, 0);
        send({3'd3, 7'h40, 2'b11, 20'h3});
        chk(err == 1, "R2 err after bad client", err, 1);

        do_reset();
        for (int i = 0; i < 1024; i++) sh[i] = mem[i];
        run_cmd(1, 8'hCC, 2'b11, 0, 0, 2, 2, 32'h700, 0, "R1 recovery copy");
        summary();
    end
endmodule